// File: doc/BRIEF.md
# Reset Release and Strap Capture Controller

This block brings a switch-class device out of its fundamental reset and captures the board straps that fix its start-up configuration. The active-low fundamental reset clears the block at once. Its release passes through a synchronizer before it takes effect. At the moment the synchronized release takes effect, the block freezes the straps. These are the halt request, the 4-bit mode code, the slave and master management-bus address pins and the master-bus slow-speed pin. From them it builds the two 7-bit bus addresses, each a mix of fixed bits and strap bits.

After release, the management buses are enabled and the block decides when the core may leave reset. In halt mode the core stays in reset while the buses serve register accesses, until a register write clears the halt bit. Mode 1 asks an external configuration-memory loader to run and waits for its done or error report. Mode 0 releases the core at once. A reserved mode code keeps the core in reset and raises an error flag. The serial bus engines and the loader are outside this block and appear only as plain handshake pins. There is no streaming data path, so every pin is a plain control or status level or strobe.

Top module: `rst_strap_ctrl`

## Requirements
- R1: While `por_n_i` is low, `core_hold_o` is 1 and `mgmt_en_o`, `load_req_o`, `load_err_o` and `mode_err_o` are 0. This takes effect asynchronously, without waiting for a clock edge.
- R2: After `por_n_i` rises, `mgmt_en_o` reads 1 following the second rising clock edge. With mode 0 and no halt, `core_hold_o` reads 0 following the third edge.
- R3: `sbus_addr_o` bit k holds address bit k+1. Pins `sbus_pins_i[2:0]` supply bits 1 to 3 and `sbus_pins_i[3]` supplies bit 5. Bit 4 is 0 and bits 6 and 7 are 1, so the value is {1,1,pin3,0,pin2,pin1,pin0}.
- R4: `mbus_addr_o` is {1,0,1,`mbus_pins_i[3:0]`}. Pins 3..0 supply address bits 4..1, bit 5 is 1, bit 6 is 0 and bit 7 is 1.
- R5: All straps are taken on the edge at which the synchronized reset release takes effect (the second edge after `por_n_i` rises). Changes on the strap pins after that edge do not alter any output until the next fundamental reset.
- R6: `mbus_slow_o` equals the captured slow strap (1 selects 100 kHz, 0 selects 400 kHz). No write strobe or handshake input changes it.
- R7: With mode code 1, `load_req_o` is 1 and the core is held for as long as the loader reports neither done nor error. In the cycle after `load_done_i` or `load_err_i` is seen high, `load_req_o` is 0 and `core_hold_o` is 0.
- R8: A loader error seen during loading sets `load_err_o`. The core is still released, and the flag stays at 1 until the next fundamental reset.
- R9: Mode codes 2 to 15 set `mode_err_o` and keep `core_hold_o` at 1 with no load request. A halt-clear write does not change this.
- R10: If the halt strap was captured high, the core stays held with `mgmt_en_o` at 1 until `halt_clr_i` is seen high. In the following cycle the block acts on the mode code as if no halt had been requested.
- R11: `halt_clr_i`, `load_done_i` and `load_err_i` have no effect in any state that does not wait for them. These are halt-clear outside halt, and loader reports outside loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_n_i | input | 1 | Fundamental reset, active low, asynchronous assertion |
| halt_strap_i | input | 1 | Halt-in-reset strap |
| mode_strap_i | input | 4 | Mode strap: 0 normal, 1 load then normal, others reserved |
| sbus_pins_i | input | 4 | Slave bus address straps (address bits 5,3,2,1 on pins 3..0) |
| mbus_pins_i | input | 4 | Master bus address straps (address bits 4..1) |
| slow_strap_i | input | 1 | Master bus slow-speed strap |
| halt_clr_i | input | 1 | Register-write strobe clearing the halt bit |
| load_done_i | input | 1 | Loader finished strobe |
| load_err_i | input | 1 | Loader failed strobe |
| core_hold_o | output | 1 | 1 while the core is held in reset |
| mgmt_en_o | output | 1 | Management bus access enable |
| sbus_addr_o | output | 7 | Captured slave bus address |
| mbus_addr_o | output | 7 | Captured configuration-memory address |
| mbus_slow_o | output | 1 | Master bus speed select, 1 = 100 kHz |
| load_req_o | output | 1 | Request to the configuration loader |
| load_err_o | output | 1 | Sticky loader error |
| mode_err_o | output | 1 | Reserved mode code captured |

## Verification
The assertions check on every cycle the relations between outputs that hold in every state. These cover the reset levels, bus enable whenever the core runs, loading persisting until a report, single-cycle exit on a report, the sticky error, the reserved-mode hold and frozen addresses. Only the bench scenarios can show the values taken from the straps and the exact edge counts after release. They also show the effect of scrambling the straps after capture and the order of halt before mode handling, each checked against expected values computed from the requirements.

// File: rtl/rst_strap_pkg.sv
package rst_strap_pkg;
  localparam int MODE_W = 4;
  localparam int PIN_W  = 4;
  localparam int ADDR_W = 7;

  localparam logic [MODE_W-1:0] MODE_PLAIN = 4'd0;
  localparam logic [MODE_W-1:0] MODE_FETCH = 4'd1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HALT,
    SQ_FETCH,
    SQ_RUN,
    SQ_BADMODE
  } seq_state_t;

  typedef struct packed {
    logic              halt;
    logic [MODE_W-1:0] mode;
    logic [PIN_W-1:0]  spins;
    logic [PIN_W-1:0]  mpins;
    logic              slow;
  } strap_t;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import rst_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_sync_i,
  input  strap_t            pins_i,
  output strap_t            held_o,
  output logic [ADDR_W-1:0] saddr_o,
  output logic [ADDR_W-1:0] maddr_o
);
  strap_t held_q;

  // Transparent while reset is held; frozen from the release edge on.
  always_ff @(posedge clk_i) begin
    if (!rst_n_sync_i) held_q <= pins_i;
  end

  assign held_o  = held_q;
  assign saddr_o = {2'b11, held_q.spins[3], 1'b0, held_q.spins[2:0]};
  assign maddr_o = {3'b101, held_q.mpins};
endmodule

// File: rtl/release_seq.sv
module release_seq
  import rst_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_sync_i,
  input  logic              halt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              halt_clr_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic              core_hold_o,
  output logic              load_req_o,
  output logic              load_err_o,
  output logic              mode_err_o
);
  seq_state_t state_q, state_d;
  logic       err_q;

  function automatic seq_state_t by_mode(input logic [MODE_W-1:0] m);
    if (m == MODE_PLAIN)      return SQ_RUN;
    else if (m == MODE_FETCH) return SQ_FETCH;
    else                      return SQ_BADMODE;
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:  state_d = halt_i ? SQ_HALT : by_mode(mode_i);
      SQ_HALT:  if (halt_clr_i) state_d = by_mode(mode_i);
      SQ_FETCH: if (done_i || err_i) state_d = SQ_RUN;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_sync_i) begin
    if (!rst_n_sync_i) begin
      state_q <= SQ_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_FETCH && err_i) err_q <= 1'b1;
    end
  end

  assign core_hold_o = (state_q != SQ_RUN);
  assign load_req_o  = (state_q == SQ_FETCH);
  assign mode_err_o  = (state_q == SQ_BADMODE);
  assign load_err_o  = err_q;
endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
  import rst_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              halt_strap_i,
  input  logic [MODE_W-1:0] mode_strap_i,
  input  logic [PIN_W-1:0]  sbus_pins_i,
  input  logic [PIN_W-1:0]  mbus_pins_i,
  input  logic              slow_strap_i,
  input  logic              halt_clr_i,
  input  logic              load_done_i,
  input  logic              load_err_i,
  output logic              core_hold_o,
  output logic              mgmt_en_o,
  output logic [ADDR_W-1:0] sbus_addr_o,
  output logic [ADDR_W-1:0] mbus_addr_o,
  output logic              mbus_slow_o,
  output logic              load_req_o,
  output logic              load_err_o,
  output logic              mode_err_o
);
  logic   rst_n_sync;
  strap_t pins, held;

  assign pins = '{halt: halt_strap_i, mode: mode_strap_i, spins: sbus_pins_i,
                  mpins: mbus_pins_i, slow: slow_strap_i};

  rst_release_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .arst_n_i(por_n_i), .rst_n_o(rst_n_sync)
  );

  strap_capture cap_i (
    .clk_i(clk_i), .rst_n_sync_i(rst_n_sync), .pins_i(pins), .held_o(held),
    .saddr_o(sbus_addr_o), .maddr_o(mbus_addr_o)
  );

  release_seq seq_i (
    .clk_i(clk_i), .rst_n_sync_i(rst_n_sync), .halt_i(held.halt), .mode_i(held.mode),
    .halt_clr_i(halt_clr_i), .done_i(load_done_i), .err_i(load_err_i),
    .core_hold_o(core_hold_o), .load_req_o(load_req_o),
    .load_err_o(load_err_o), .mode_err_o(mode_err_o)
  );

  assign mgmt_en_o   = rst_n_sync;
  assign mbus_slow_o = held.slow;
endmodule

// File: rtl/rst_strap_ctrl_chk.sv
module rst_strap_ctrl_chk (
  input logic       clk_i,
  input logic       por_n_i,
  input logic       load_done_i,
  input logic       load_err_i,
  input logic       core_hold_o,
  input logic       mgmt_en_o,
  input logic [6:0] sbus_addr_o,
  input logic [6:0] mbus_addr_o,
  input logic       mbus_slow_o,
  input logic       load_req_o,
  input logic       load_err_o,
  input logic       mode_err_o
);
  always @(posedge clk_i) begin
    if (!por_n_i)
      assert_reset_levels_R1: assert (core_hold_o && !mgmt_en_o && !load_req_o
                                       && !load_err_o && !mode_err_o);
  end

  assert_run_has_bus_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !core_hold_o |-> mgmt_en_o);

  assert_load_waits_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    load_req_o && !load_done_i && !load_err_i |=> load_req_o && core_hold_o);

  assert_load_exit_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    load_req_o && (load_done_i || load_err_i) |=> !load_req_o && !core_hold_o);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    load_err_o |=> load_err_o);

  assert_badmode_hold_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    mode_err_o |-> core_hold_o && !load_req_o);

  assert_frozen_straps_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    mgmt_en_o && $past(mgmt_en_o) |-> $stable(sbus_addr_o) && $stable(mbus_addr_o)
                                      && $stable(mbus_slow_o));

  assert_run_stays_R11: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !core_hold_o |=> !core_hold_o);
endmodule

bind rst_strap_ctrl rst_strap_ctrl_chk chk_i (
  .clk_i(clk_i), .por_n_i(por_n_i), .load_done_i(load_done_i), .load_err_i(load_err_i),
  .core_hold_o(core_hold_o), .mgmt_en_o(mgmt_en_o), .sbus_addr_o(sbus_addr_o),
  .mbus_addr_o(mbus_addr_o), .mbus_slow_o(mbus_slow_o), .load_req_o(load_req_o),
  .load_err_o(load_err_o), .mode_err_o(mode_err_o)
);

// File: tb/rst_strap_ctrl_tb.sv
`timescale 1ns/1ps
module rst_strap_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       halt_strap = 1'b0;
  logic [3:0] mode_strap = 4'd0;
  logic [3:0] s_strap = 4'd0;
  logic [3:0] m_strap = 4'd0;
  logic       slow_strap = 1'b0;
  logic       clr = 1'b0, done = 1'b0, lerr = 1'b0;
  logic       core, mgmt, slow, lreq, lerr_o, merr;
  logic [6:0] saddr, maddr;
  int         compared = 0, mismatched = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  rst_strap_ctrl dut_i (
    .clk_i(clk), .por_n_i(por_n), .halt_strap_i(halt_strap), .mode_strap_i(mode_strap),
    .sbus_pins_i(s_strap), .mbus_pins_i(m_strap), .slow_strap_i(slow_strap),
    .halt_clr_i(clr), .load_done_i(done), .load_err_i(lerr),
    .core_hold_o(core), .mgmt_en_o(mgmt), .sbus_addr_o(saddr), .mbus_addr_o(maddr),
    .mbus_slow_o(slow), .load_req_o(lreq), .load_err_o(lerr_o), .mode_err_o(merr)
  );

  function automatic logic [6:0] exp_saddr(input logic [3:0] p);
    return {1'b1, 1'b1, p[3], 1'b0, p[2], p[1], p[0]};
  endfunction

  function automatic logic [6:0] exp_maddr(input logic [3:0] p);
    return {1'b1, 1'b0, 1'b1, p};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic d, input logic e);
    clr = c; done = d; lerr = e;
    @(negedge clk);
    clr = 1'b0; done = 1'b0; lerr = 1'b0;
  endtask

  task automatic run_case(input logic [3:0] mode, input logic halt, input logic [3:0] sp,
                          input logic [3:0] mp, input logic sl, input int lat, input logic err);
    logic [6:0] es, em;
    es = exp_saddr(sp);
    em = exp_maddr(mp);
    @(negedge clk);
    por_n = 1'b0; halt_strap = halt; mode_strap = mode;
    s_strap = sp; m_strap = mp; slow_strap = sl;
    clr = 1'b0; done = 1'b0; lerr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 core held in reset", core, 1);
    check("R1 bus off in reset", mgmt, 0);
    check("R1 no load request", lreq, 0);
    check("R1 flags clear", {lerr_o, merr}, 0);
    por_n = 1'b1;
    @(negedge clk);
    check("R2 bus off after first edge", mgmt, 0);
    @(negedge clk);
    check("R2 bus on after second edge", mgmt, 1);
    check("R2 core held at second edge", core, 1);
    check("R3 slave address", saddr, es);
    check("R4 master address", maddr, em);
    check("R6 slow select", slow, sl);
    halt_strap = ~halt; mode_strap = ~mode; s_strap = ~sp; m_strap = ~mp; slow_strap = ~sl;
    @(negedge clk);
    if (halt) begin
      check("R10 halted core held", core, 1);
      check("R10 halted bus on", mgmt, 1);
      check("R10 no request while halted", lreq, 0);
      repeat (lat) @(negedge clk);
      pulse(1'b0, 1'b1, 1'b1);
      check("R11 loader report ignored in halt", {core, lreq, lerr_o}, 3'b100);
      pulse(1'b1, 1'b0, 1'b0);
    end
    if (mode > 4'd1) begin
      check("R9 mode error flag", merr, 1);
      check("R9 core held", core, 1);
      check("R9 no request", lreq, 0);
      pulse(1'b1, 1'b0, 1'b0);
      check("R9 halt clear ignored", {merr, core}, 2'b11);
    end else if (mode == 4'd1) begin
      check("R7 load requested", lreq, 1);
      check("R7 core held while loading", core, 1);
      repeat (lat) @(negedge clk);
      check("R7 still waiting", {lreq, core}, 2'b11);
      pulse(1'b0, !err, err);
      check("R7 core released after report", core, 0);
      check("R7 request dropped", lreq, 0);
      check("R8 error sticky value", lerr_o, err);
    end else begin
      check("R2 core released", core, 0);
      check("R10 no load request in mode 0", lreq, 0);
    end
    if (mode <= 4'd1) begin
      pulse(1'b1, 1'b1, 1'b1);
      check("R11 strobes ignored in run", core, 0);
      check("R11 error flag unchanged", lerr_o, (mode == 4'd1) && err);
      check("R8 error persists", lerr_o, (mode == 4'd1) && err);
    end
    check("R5 slave address frozen", saddr, es);
    check("R5 master address frozen", maddr, em);
    check("R6 slow select unaffected", slow, sl);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    run_case(4'd0, 1'b0, 4'h0, 4'h0, 1'b0, 0, 1'b0);
    run_case(4'd0, 1'b0, 4'hF, 4'hF, 1'b1, 0, 1'b0);
    run_case(4'd1, 1'b0, 4'h5, 4'hA, 1'b0, 3, 1'b0);
    run_case(4'd1, 1'b0, 4'hA, 4'h5, 1'b1, 0, 1'b1);
    run_case(4'd0, 1'b1, 4'h9, 4'h6, 1'b0, 4, 1'b0);
    run_case(4'd15, 1'b1, 4'h3, 4'hC, 1'b1, 1, 1'b0);
    run_case(4'd2, 1'b0, 4'h8, 4'h1, 1'b0, 0, 1'b0);
    run_case(4'd1, 1'b1, 4'h7, 4'h8, 1'b1, 2, 1'b1);
    // R1: reset asserts without a clock edge
    @(negedge clk);
    #0.5 por_n = 1'b0;
    #0.5 check("R1 asynchronous hold", {core, mgmt}, 2'b10);
    for (int i = 0; i < 40; i++) begin
      logic [3:0] md;
      int unsigned r;
      r = $urandom % 8;
      md = (r < 3) ? 4'd0 : (r < 6) ? 4'd1 : 4'(2 + ($urandom % 14));
      run_case(md, ($urandom % 3) == 0, 4'($urandom), 4'($urandom), 1'($urandom),
               int'($urandom % 5), 1'($urandom));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule